// File: doc/BRIEF.md
# Storage Command Sequencer

This block sits between user logic and a block-storage host engine. It takes one command at a time over a request/busy handshake, checks it against the rules of the drive's life cycle, and turns it into one or more device sub-commands. The command is a 3-bit opcode, a 48-bit start sector and a 48-bit sector count, where a sector is 512 bytes. Write and read transfers are cut into sub-commands of at most 256 sectors (128 KB). The final sub-command carries whatever sectors remain.

Each sub-command leaves the block as a one-cycle launch pulse with its opcode, sector address and sector count. The block then waits for a completion pulse that carries a status word. A programmable stall limit bounds that wait. A write sub-command is held back until the data source reports enough sectors for it. A read sub-command is held back until the sink reports enough free space. After the last read sub-command, the block waits for the sink to report that it has drained.

The block moves no data, so it has no valid/ready stream. The only back-pressure comes from the two sector-count inputs and the drain flag. These stall the launch of the next sub-command. They never cancel one that has already launched. Faults are kept in an error word that only a reset clears.

Top module: `stor_cmd_seq`

## Requirements
- R1: From reset until `init_done` is seen high, `busy` is 1. Requests raised in that time are ignored and never launch a sub-command.
- R2: A request is taken only while the block is idle. `busy` is 1 in the cycle after the accepting clock edge. It stays 1 until the command is complete and then returns to 0. A sub-command launch only happens while `busy` is 1.
- R3: Opcode encoding: 000 identify, 001 shutdown, 010 write, 011 read, 100 custom, 110 flush. Identify, shutdown and custom are admin commands; write, read and flush are I/O commands. Identify, shutdown, flush and custom each launch exactly one sub-command, with address 0 and count 0. `sub_start` is a single-cycle pulse.
- R4: A write or read of N sectors at address A launches ceil(N/256) sub-commands. The sub-commands go out in order, at addresses A, A+256, and so on. Each has a count of 256, except the last, which carries the remainder.
- R5: A write sub-command launches only when `wr_avail` is at least its count. A read sub-command launches only when `rd_free` is at least its count.
- R6: After the last read sub-command completes, `busy` stays 1 until `rd_drained` is 1. It falls in the cycle after the edge that samples `rd_drained` high.
- R7: Identify must be the first command after reset. When identify completes with good status, `id_cap` is latched to `lba_size` and `id_lba4k` is latched to `lba_mode`.
- R8: The block rejects a request with any of these faults:
  - a reserved opcode (101, 111);
  - any opcode other than identify before an identify has completed;
  - a write or read of count 0;
  - in 4 KB mode (`lba_mode`=1), address or count with nonzero low three bits;
  - address plus count greater than `lba_size`.

  On a rejection the block sets `err_type` bit 9, launches nothing, and halts with `busy` at 0.
- R9: When `tmo_limit` is nonzero and no completion arrives within about `tmo_limit` cycles after a launch, the block sets bit 2 (admin command) or bit 4 (I/O command) of `err_type` and halts. A `tmo_limit` of 0 waits without limit.
- R10: A completion with nonzero `sub_status` sets bit 3 (admin) or bit 5 (I/O) of `err_type`. It ends the splitting loop, so no further sub-command launches, and the block halts with `busy` at 0.
- R11: `err_flag` equals the OR of `err_type`. Bits of `err_type` never clear except on reset. A halted block ignores every request.
- R12: After a shutdown completes, the block is inactive: `busy` is 0 and requests launch nothing until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Host engine initialization finished |
| req | input | 1 | Command request |
| req_op | input | 3 | Command opcode |
| req_addr | input | 48 | Start sector |
| req_len | input | 48 | Sector count |
| busy | output | 1 | Command in progress or initialization pending |
| tmo_limit | input | 32 | Completion wait limit in cycles, 0 disables |
| wr_avail | input | 16 | Write sectors ready at the source |
| rd_free | input | 16 | Free sector space at the read sink |
| rd_drained | input | 1 | Read sink is empty |
| sub_start | output | 1 | Sub-command launch pulse |
| sub_op | output | 3 | Sub-command opcode |
| sub_addr | output | 48 | Sub-command start sector |
| sub_len | output | 9 | Sub-command sector count |
| sub_done | input | 1 | Sub-command completion pulse |
| sub_status | input | 16 | Completion status, 0 means good |
| id_cap | input | 48 | Capacity in sectors delivered by identify |
| id_lba4k | input | 1 | 4 KB sector mode delivered by identify |
| lba_size | output | 48 | Latched capacity |
| lba_mode | output | 1 | Latched sector mode |
| err_flag | output | 1 | Any error latched |
| err_type | output | 32 | Latched error bits |

## Verification
The bound checker watches several properties on every cycle:
- launches are single-cycle pulses, occur only while busy, and never exceed 256 sectors;
- write and read launches are gated by the availability counts of the previous cycle;
- error bits are sticky, and a latched error is never seen with busy high;
- a rejection never coincides with a launch.

The bench scenarios cover what needs a whole command's history:
- the address and count sequence of split transfers, including exact-fit and remainder cases;
- the drain wait;
- the life cycle of identify first and shutdown last;
- each rejection cause;
- the timeout against a limit of zero;
- a status fault stopping a transfer partway through.

// File: rtl/stor_seq_pkg.sv
package stor_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDENT  = 3'b000,
    OP_SHUT   = 3'b001,
    OP_WRITE  = 3'b010,
    OP_READ   = 3'b011,
    OP_CUSTOM = 3'b100,
    OP_RSV5   = 3'b101,
    OP_FLUSH  = 3'b110,
    OP_RSV7   = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_DRAIN,
    ST_HALT,
    ST_OFF
  } st_e;

  localparam int ERR_ADM_TMO  = 2;
  localparam int ERR_ADM_STAT = 3;
  localparam int ERR_IO_TMO   = 4;
  localparam int ERR_IO_STAT  = 5;
  localparam int ERR_REJECT   = 9;

  function automatic logic is_admin(input op_e op);
    return (op == OP_IDENT) || (op == OP_SHUT) || (op == OP_CUSTOM);
  endfunction

  function automatic logic is_xfer(input op_e op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic logic is_reserved(input op_e op);
    return (op == OP_RSV5) || (op == OP_RSV7);
  endfunction

endpackage

// File: rtl/stor_req_check.sv
module stor_req_check
  import stor_seq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int ALIGN_BITS = 3
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] len,
  input  logic              id_done,
  input  logic              mode4k,
  input  logic [ADDR_W-1:0] cap,
  output logic              ok
);

  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] end_sect;
  logic             bad_op, bad_order, bad_len, bad_align, bad_cap;

  always_comb begin
    end_sect  = {1'b0, addr} + {1'b0, len};
    bad_op    = is_reserved(op);
    bad_order = !id_done && (op != OP_IDENT);
    bad_len   = is_xfer(op) && (len == '0);
    bad_align = is_xfer(op) && mode4k &&
                ((addr[ALIGN_BITS-1:0] != '0) || (len[ALIGN_BITS-1:0] != '0));
    bad_cap   = is_xfer(op) && (end_sect > {1'b0, cap});
    ok        = !(bad_op || bad_order || bad_len || bad_align || bad_cap);
  end

endmodule

// File: rtl/stor_chunk_track.sv
module stor_chunk_track #(
  parameter int ADDR_W = 48,
  parameter int CHUNK_SECT = 256,
  localparam int CLEN_W = $clog2(CHUNK_SECT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] load_len,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CLEN_W-1:0] chunk,
  output logic              final_chunk
);

  localparam logic [ADDR_W-1:0] CHUNK_FULL = ADDR_W'(CHUNK_SECT);

  logic [ADDR_W-1:0] remain;

  always_comb begin
    if (remain >= CHUNK_FULL) chunk = CLEN_W'(CHUNK_SECT);
    else                      chunk = remain[CLEN_W-1:0];
    final_chunk = (remain <= CHUNK_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (advance) begin
      cur_addr <= cur_addr + ADDR_W'(chunk);
      remain   <= remain - ADDR_W'(chunk);
    end
  end

endmodule

// File: rtl/stor_stall_timer.sv
module stor_stall_timer #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (run && (cnt != '1))    cnt <= cnt + 1'b1;
  end

  assign expired = run && (limit != '0) && (cnt >= limit);

endmodule

// File: rtl/stor_cmd_seq.sv
module stor_cmd_seq
  import stor_seq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CHUNK_SECT = 256,
  parameter int TMO_W = 32,
  parameter int CNT_W = 16,
  parameter int STAT_W = 16,
  parameter int ERR_W = 32,
  localparam int CLEN_W = $clog2(CHUNK_SECT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              req,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [CNT_W-1:0]  wr_avail,
  input  logic [CNT_W-1:0]  rd_free,
  input  logic              rd_drained,
  output logic              sub_start,
  output logic [2:0]        sub_op,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [CLEN_W-1:0] sub_len,
  input  logic              sub_done,
  input  logic [STAT_W-1:0] sub_status,
  input  logic [ADDR_W-1:0] id_cap,
  input  logic              id_lba4k,
  output logic [ADDR_W-1:0] lba_size,
  output logic              lba_mode,
  output logic              err_flag,
  output logic [ERR_W-1:0]  err_type
);

  st_e               st;
  op_e               op_q;
  op_e               op_in;
  logic              id_done;
  logic              req_ok;
  logic              accept, reject, wait_ok, launch;
  logic              good_done, bad_done, tmo_hit;
  logic [ADDR_W-1:0] cur_addr;
  logic [CLEN_W-1:0] chunk;
  logic              final_chunk;
  logic              expired;

  assign op_in = op_e'(req_op);

  stor_req_check #(.ADDR_W(ADDR_W)) u_check (
    .op      (op_in),
    .addr    (req_addr),
    .len     (req_len),
    .id_done (id_done),
    .mode4k  (lba_mode),
    .cap     (lba_size),
    .ok      (req_ok)
  );

  always_comb begin
    accept    = (st == ST_IDLE) && req && req_ok;
    reject    = (st == ST_IDLE) && req && !req_ok;
    wait_ok   = (st == ST_WAIT) &&
                ((op_q == OP_WRITE) ? (wr_avail >= CNT_W'(chunk))
                                    : (rd_free  >= CNT_W'(chunk)));
    launch    = (accept && !is_xfer(op_in)) || wait_ok;
    good_done = (st == ST_RUN) && sub_done && (sub_status == '0);
    bad_done  = (st == ST_RUN) && sub_done && (sub_status != '0);
    tmo_hit   = (st == ST_RUN) && !sub_done && expired;
  end

  stor_chunk_track #(.ADDR_W(ADDR_W), .CHUNK_SECT(CHUNK_SECT)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_addr   (req_addr),
    .load_len    (req_len),
    .advance     (good_done && is_xfer(op_q)),
    .cur_addr    (cur_addr),
    .chunk       (chunk),
    .final_chunk (final_chunk)
  );

  stor_stall_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (launch),
    .run     (st == ST_RUN),
    .limit   (tmo_limit),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      op_q      <= OP_IDENT;
      id_done   <= 1'b0;
      lba_size  <= '0;
      lba_mode  <= 1'b0;
      err_type  <= '0;
      sub_start <= 1'b0;
      sub_op    <= '0;
      sub_addr  <= '0;
      sub_len   <= '0;
    end else begin
      sub_start <= launch;
      if (accept && !is_xfer(op_in)) begin
        sub_op   <= req_op;
        sub_addr <= '0;
        sub_len  <= '0;
      end else if (wait_ok) begin
        sub_op   <= op_q;
        sub_addr <= cur_addr;
        sub_len  <= chunk;
      end

      unique case (st)
        ST_INIT:  if (init_done) st <= ST_IDLE;
        ST_IDLE: begin
          if (accept) begin
            op_q <= op_in;
            st   <= is_xfer(op_in) ? ST_WAIT : ST_RUN;
          end else if (reject) begin
            err_type[ERR_REJECT] <= 1'b1;
            st <= ST_HALT;
          end
        end
        ST_WAIT:  if (wait_ok) st <= ST_RUN;
        ST_RUN: begin
          if (bad_done) begin
            if (is_admin(op_q)) err_type[ERR_ADM_STAT] <= 1'b1;
            else                err_type[ERR_IO_STAT]  <= 1'b1;
            st <= ST_HALT;
          end else if (tmo_hit) begin
            if (is_admin(op_q)) err_type[ERR_ADM_TMO] <= 1'b1;
            else                err_type[ERR_IO_TMO]  <= 1'b1;
            st <= ST_HALT;
          end else if (good_done) begin
            if (is_xfer(op_q)) begin
              if (!final_chunk)          st <= ST_WAIT;
              else if (op_q == OP_READ)  st <= ST_DRAIN;
              else                       st <= ST_IDLE;
            end else if (op_q == OP_IDENT) begin
              id_done  <= 1'b1;
              lba_size <= id_cap;
              lba_mode <= id_lba4k;
              st       <= ST_IDLE;
            end else if (op_q == OP_SHUT) begin
              st <= ST_OFF;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_DRAIN: if (rd_drained) st <= ST_IDLE;
        ST_HALT:  st <= ST_HALT;
        ST_OFF:   st <= ST_OFF;
        default:  st <= ST_HALT;
      endcase
    end
  end

  assign busy     = !((st == ST_IDLE) || (st == ST_HALT) || (st == ST_OFF));
  assign err_flag = |err_type;

endmodule

// File: rtl/stor_cmd_seq_chk.sv
module stor_cmd_seq_chk #(
  parameter int ADDR_W = 48,
  parameter int CHUNK_SECT = 256,
  parameter int CNT_W = 16,
  parameter int ERR_W = 32,
  localparam int CLEN_W = $clog2(CHUNK_SECT) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sub_start,
  input logic [2:0]        sub_op,
  input logic [CLEN_W-1:0] sub_len,
  input logic [CNT_W-1:0]  wr_avail,
  input logic [CNT_W-1:0]  rd_free,
  input logic              err_flag,
  input logic [ERR_W-1:0]  err_type
);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_start |=> !sub_start);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_start |-> busy);

  // R4
  chunk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_start |-> (sub_len <= CLEN_W'(CHUNK_SECT)));

  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_start && sub_op == 3'b010) |-> ($past(wr_avail) >= CNT_W'(sub_len)));

  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_start && sub_op == 3'b011) |-> ($past(rd_free) >= CNT_W'(sub_len)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_type) & ~err_type) == '0));

  // R10
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !busy);

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_type[9]) |-> !sub_start);

endmodule

bind stor_cmd_seq stor_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .CHUNK_SECT(CHUNK_SECT), .CNT_W(CNT_W), .ERR_W(ERR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .sub_start (sub_start),
  .sub_op    (sub_op),
  .sub_len   (sub_len),
  .wr_avail  (wr_avail),
  .rd_free   (rd_free),
  .err_flag  (err_flag),
  .err_type  (err_type)
);

// File: tb/stor_cmd_seq_test.sv
`timescale 1ns/1ps
module stor_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  req_op = '0;
  logic [47:0] req_addr = '0, req_len = '0;
  logic        busy;
  logic [31:0] tmo_limit = '0;
  logic [15:0] wr_avail = '0, rd_free = '0;
  logic        rd_drained = 1'b0;
  logic        sub_start;
  logic [2:0]  sub_op;
  logic [47:0] sub_addr;
  logic [8:0]  sub_len;
  logic        sub_done = 1'b0;
  logic [15:0] sub_status = '0;
  logic [47:0] id_cap = '0;
  logic        id_lba4k = 1'b0;
  logic [47:0] lba_size;
  logic        lba_mode, err_flag;
  logic [31:0] err_type;

  always #4 clk = ~clk;

  stor_cmd_seq uut (.*);

  int checks = 0, fails = 0, starts = 0, bad_at = -1, dly = 3;
  bit silent = 0, ended = 0;
  logic [59:0] expq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor / device model: pops expected sub-commands and answers them
  initial forever begin
    @(negedge clk);
    if (rst_n && sub_start) begin
      starts++;
      if (expq.size() == 0) chk(0, "R4 unexpected sub-command", {sub_op, sub_addr, sub_len}, 0);
      else begin
        logic [59:0] e;
        e = expq.pop_front();
        chk({sub_op, sub_addr, sub_len} == e, "R4 sub-command fields", {sub_op, sub_addr, sub_len}, e);
      end
      if (!silent) begin
        repeat (dly) @(negedge clk);
        sub_status = (starts == bad_at) ? 16'h0002 : 16'h0000;
        sub_done = 1'b1;
        @(negedge clk);
        sub_done = 1'b0;
        sub_status = '0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic push(input logic [2:0] op, input logic [47:0] a, input logic [8:0] l);
    expq.push_back({op, a, l});
  endtask

  task automatic send(input logic [2:0] op, input logic [47:0] a, input logic [47:0] l);
    req_op = op; req_addr = a; req_len = l; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; init_done = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bringup(input logic [47:0] cap, input logic m4k);
    do_reset();
    init_done = 1'b1;
    @(negedge clk);
    id_cap = cap; id_lba4k = m4k;
    push(3'b000, 0, 0);
    send(3'b000, 0, 0);
    wait_idle();
  endtask

  int s0;

  initial begin
    @(negedge clk);
    do_reset();
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(err_type == 0 && !err_flag, "R11 error clear after reset", err_type, 0);
    send(3'b010, 0, 8);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && starts == 0, "R1 request ignored during init", starts, 0);
    init_done = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy falls after init", busy, 0);

    // write before identify is rejected
    send(3'b010, 0, 8);
    chk(err_type == 32'h200 && err_flag, "R7 non-identify first rejected", err_type, 32'h200);
    send(3'b110, 0, 0);
    repeat (5) @(negedge clk);
    chk(starts == 0 && busy == 0, "R11 halted block ignores request", starts, 0);

    // normal life cycle
    bringup(48'd10000, 1'b0);
    chk(lba_size == 10000 && lba_mode == 0, "R7 identify latches capacity", lba_size, 10000);
    chk(err_type == 0, "R7 identify no error", err_type, 0);

    wr_avail = 16'd100; rd_free = 16'd300; rd_drained = 1'b0;
    push(3'b010, 100, 256); push(3'b010, 356, 256); push(3'b010, 612, 88);
    s0 = starts;
    send(3'b010, 100, 600);
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    repeat (10) @(negedge clk);
    chk(starts == s0, "R5 write held until data available", starts, s0);
    wr_avail = 16'd256;
    wait_idle();
    chk(expq.size() == 0 && starts == s0 + 3, "R4 write split 256/256/88", starts - s0, 3);

    push(3'b011, 0, 256); push(3'b011, 256, 1);
    send(3'b011, 0, 257);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1 && expq.size() == 0, "R6 read waits for drain", busy, 1);
    rd_drained = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy falls after drain", busy, 0);

    push(3'b010, 9744, 256);
    s0 = starts;
    send(3'b010, 9744, 256);
    wait_idle();
    chk(starts == s0 + 1 && err_type == 0, "R8 exact-fit transfer accepted", starts - s0, 1);

    tmo_limit = 0; dly = 60;
    push(3'b110, 0, 0);
    s0 = starts;
    send(3'b110, 0, 0);
    wait_idle();
    chk(err_type == 0 && starts == s0 + 1, "R9 zero limit waits without timeout", err_type, 0);
    dly = 3;
    push(3'b100, 0, 0);
    send(3'b100, 0, 0);
    wait_idle();
    chk(starts == s0 + 2 && err_type == 0, "R3 custom single sub-command", starts - s0, 2);

    push(3'b001, 0, 0);
    send(3'b001, 0, 0);
    wait_idle();
    s0 = starts;
    send(3'b110, 0, 0);
    repeat (6) @(negedge clk);
    chk(starts == s0 && busy == 0 && err_type == 0, "R12 inactive after shutdown", starts, s0);

    // rejection causes
    bringup(48'd10000, 1'b0);
    s0 = starts;
    send(3'b010, 9990, 11);
    chk(err_type == 32'h200, "R8 capacity overrun rejected", err_type, 32'h200);
    bringup(48'd10000, 1'b0);
    send(3'b101, 0, 8);
    chk(err_type == 32'h200, "R8 reserved opcode rejected", err_type, 32'h200);
    bringup(48'd8000, 1'b1);
    chk(lba_mode == 1'b1, "R7 4K mode latched", lba_mode, 1);
    s0 = starts;
    send(3'b010, 4, 8);
    repeat (3) @(negedge clk);
    chk(err_type == 32'h200 && starts == s0, "R8 misaligned 4K rejected", err_type, 32'h200);

    // status fault mid-transfer
    bringup(48'd10000, 1'b0);
    tmo_limit = 32'd20;
    s0 = starts;
    bad_at = s0 + 2;
    push(3'b010, 100, 256); push(3'b010, 356, 256);
    send(3'b010, 100, 600);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(err_type == 32'h20 && busy == 0, "R10 I/O status fault", err_type, 32'h20);
    chk(starts == s0 + 2 && expq.size() == 0, "R10 splitting stops", starts - s0, 2);
    bad_at = -1;

    // timeouts
    bringup(48'd10000, 1'b0);
    silent = 1;
    push(3'b110, 0, 0);
    send(3'b110, 0, 0);
    repeat (10) @(negedge clk);
    chk(err_type == 0 && busy == 1, "R9 no timeout before limit", err_type, 0);
    repeat (30) @(negedge clk);
    chk(err_type == 32'h10, "R9 I/O timeout bit 4", err_type, 32'h10);
    silent = 0;
    bringup(48'd10000, 1'b0);
    silent = 1;
    push(3'b100, 0, 0);
    send(3'b100, 0, 0);
    repeat (40) @(negedge clk);
    chk(err_type == 32'h4 && err_flag, "R9 admin timeout bit 2", err_type, 32'h4);
    silent = 0;

    chk(expq.size() == 0, "R4 all expected sub-commands seen", expq.size(), 0);
    finish_run();
  end

endmodule